// File: doc/BRIEF.md
# Half-Wave Voltage Limit Compensator

This block computes the switching thresholds for a three-step, seven-level modulator. It computes them once for the positive half-wave and once for the negative half-wave. Each threshold is the fraction of the half-wave's total module voltage reached once the module in a given role, and those below it, are switched in. The results are unsigned Q1.15 numbers, so 1.0 is 32768.

After a fault, different modules serve the two polarities, so their voltage sums can differ. In this case the block also produces a gain below unity for the half-wave with the larger sum, so that both half-waves reach the same peak.

A start strobe launches a new calculation. The caller issues it once per half-period of the reference. One shared restoring divider, producing one quotient bit per cycle, works through the quotients in turn. All outputs update together in the cycle of a one-cycle valid pulse.

Top module: `hw_limit_comp`

## Requirements
- R1: The outermost thresholds of both polarities are constant: limit 0 is 0 and limit 3 is 32768 (1.0 in Q1.15).
- R2: Positive limit 1 equals floor(v1 * 32768 / (v1 + v2 + v3)), where v1, v2 and v3 are the positive role-1, role-2 and role-3 voltages latched at the accepted start.
- R3: Positive limit 2 equals floor((v1 + v2) * 32768 / (v1 + v2 + v3)) over the same latched positive set.
- R4: With fault mode high at the start, negative limits 1 and 2 follow the same formulas as R2 and R3, using only the negative role-1..3 voltages.
- R5: In fault mode the gain equals floor(min(Sp, Sn) * 32768 / max(Sp, Sn)), where Sp and Sn are the positive and negative sums. The polarity flag is 1 exactly when Sn > Sp, meaning the gain applies to the negative half-wave; it is 0 when the gain applies to the positive half-wave.
- R6: In fault mode with Sp equal to Sn, the gain is exactly 32768 and the polarity flag is 0.
- R7: With fault mode low at the start, the negative voltage inputs have no effect. Both polarities receive the limits computed from the positive set, the gain is 32768 and the flag is 0.
- R8: A start is ignored, with no valid pulse and all outputs held, when the sum that the calculation needs is zero. In normal mode that is Sp; in fault mode it is either Sp or Sn.
- R9: Valid is high for a single cycle, and the outputs change only in that cycle. A start that arrives while a calculation is in progress is ignored.
- R10: The outputs always satisfy limit 0 ≤ limit 1 ≤ limit 2 ≤ limit 3 for each polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_mode | input | 1 | High selects independent per-polarity compensation |
| start | input | 1 | Strobe that launches a calculation |
| pos_v1 | input | VW | Positive half-wave, role-1 module voltage |
| pos_v2 | input | VW | Positive half-wave, role-2 module voltage |
| pos_v3 | input | VW | Positive half-wave, role-3 module voltage |
| neg_v1 | input | VW | Negative half-wave, role-1 module voltage |
| neg_v2 | input | VW | Negative half-wave, role-2 module voltage |
| neg_v3 | input | VW | Negative half-wave, role-3 module voltage |
| pos_lim0 | output | FW+1 | Positive limit 0 (always 0) |
| pos_lim1 | output | FW+1 | Positive limit 1 |
| pos_lim2 | output | FW+1 | Positive limit 2 |
| pos_lim3 | output | FW+1 | Positive limit 3 (always 1.0) |
| neg_lim0 | output | FW+1 | Negative limit 0 (always 0) |
| neg_lim1 | output | FW+1 | Negative limit 1 |
| neg_lim2 | output | FW+1 | Negative limit 2 |
| neg_lim3 | output | FW+1 | Negative limit 3 (always 1.0) |
| gain | output | FW+1 | Amplitude correction factor, Q1.15 |
| gain_neg | output | 1 | 1: gain applies to the negative half-wave |
| valid | output | 1 | One-cycle pulse when the outputs update |

## Verification
The bench runs with 4-bit voltages. It sweeps every positive triple drawn from {0, 2, 5, 9, 15}, once in normal mode and once in fault mode, against several negative triples.

- **Normal-mode sweep.** The negative triples are deliberately different from the positive ones, so a design that reads them leaks into the negative limits.
- **Fault-mode sweep.** The negative triples include some whose sums are below, equal to and above the positive sums. These separate a wrong polarity flag, a gain that is inverted or applied to the wrong side, and the exact-unity case for equal sums.
- **Zero sums.** All-zero triples in either mode test that the start is dropped and the previous results are held.
- **Start while busy.** A second start with different voltages, issued mid-calculation, tests that the first set's results come out.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   // Order in which the shared divider works through the quotients.
   typedef enum logic [2:0] {
      JOB_P1   = 3'd0,
      JOB_P2   = 3'd1,
      JOB_N1   = 3'd2,
      JOB_N2   = 3'd3,
      JOB_GAIN = 3'd4
   } job_e;

endpackage

// File: rtl/hwc_divider.sv
// Restoring divider for num <= den; quot = floor(num * 2^(QW-1) / den).
module hwc_divider #(
   parameter int NW = 14,
   parameter int QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   input  logic [NW-1:0] den,
   output logic          done,
   output logic [QW-1:0] quot
);
   localparam int CW = $clog2(QW + 1);

   logic [NW:0]   rem_q;
   logic [NW-1:0] den_q;
   logic [CW-1:0] cnt_q;
   logic [NW:0]   diff;
   logic          take;

   if (QW < 2) begin : g_qw_bad
      $error("hwc_divider: QW must be at least 2");
   end

   always_comb begin
      take = (rem_q >= {1'b0, den_q});
      diff = rem_q - {1'b0, den_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         quot  <= '0;
         done  <= 1'b0;
      end else if (go) begin
         rem_q <= {1'b0, num};
         den_q <= den;
         cnt_q <= CW'(QW);
         quot  <= '0;
         done  <= 1'b0;
      end else if (cnt_q != '0) begin
         if (take) begin
            quot  <= {quot[QW-2:0], 1'b1};
            rem_q <= {diff[NW-1:0], 1'b0};
         end else begin
            quot  <= {quot[QW-2:0], 1'b0};
            rem_q <= {rem_q[NW-1:0], 1'b0};
         end
         cnt_q <= cnt_q - 1'b1;
         done  <= (cnt_q == CW'(1));
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/hwc_clamp.sv
// Forces lo <= hi <= 1.0 on a pair of raw thresholds.
module hwc_clamp #(
   parameter int QW = 16,
   parameter int FW = 15
) (
   input  logic [QW-1:0] raw_lo,
   input  logic [QW-1:0] raw_hi,
   output logic [QW-1:0] lim_lo,
   output logic [QW-1:0] lim_hi
);
   localparam logic [QW-1:0] ONE = QW'(1) << FW;

   logic [QW-1:0] hi_up;

   always_comb begin
      lim_lo = (raw_lo > ONE) ? ONE : raw_lo;
      hi_up  = (raw_hi < lim_lo) ? lim_lo : raw_hi;
      lim_hi = (hi_up > ONE) ? ONE : hi_up;
   end
endmodule

// File: rtl/hw_limit_comp.sv
module hw_limit_comp #(
   parameter int VW = 12,
   parameter int FW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fault_mode,
   input  logic          start,
   input  logic [VW-1:0] pos_v1,
   input  logic [VW-1:0] pos_v2,
   input  logic [VW-1:0] pos_v3,
   input  logic [VW-1:0] neg_v1,
   input  logic [VW-1:0] neg_v2,
   input  logic [VW-1:0] neg_v3,
   output logic [FW:0]   pos_lim0,
   output logic [FW:0]   pos_lim1,
   output logic [FW:0]   pos_lim2,
   output logic [FW:0]   pos_lim3,
   output logic [FW:0]   neg_lim0,
   output logic [FW:0]   neg_lim1,
   output logic [FW:0]   neg_lim2,
   output logic [FW:0]   neg_lim3,
   output logic [FW:0]   gain,
   output logic          gain_neg,
   output logic          valid
);
   localparam int SW = VW + 2;
   localparam int QW = FW + 1;
   localparam logic [QW-1:0] ONE = QW'(1) << FW;

   if (VW < 2 || VW > 28) begin : g_vw_bad
      $error("hw_limit_comp: VW out of range");
   end
   if (FW < 4 || FW > 30) begin : g_fw_bad
      $error("hw_limit_comp: FW out of range");
   end

   // Input sums and the admission decision
   logic [SW-1:0] psum_in, nsum_in;
   logic          zero_in, accept;

   // Latched operands
   logic          run_q, mode_q;
   logic [SW-1:0] pv1_q, pv12_q, psum_q;
   logic [SW-1:0] nv1_q, nv12_q, nsum_q;

   // Sequencing
   hwc_pkg::job_e job_q;
   logic          go_q, commit_q, last_job;
   logic [SW-1:0] div_num, div_den;
   logic          div_done;
   logic [QW-1:0] div_quot;

   // Raw quotients: [0] positive, [1] negative
   logic [QW-1:0] raw_lo [2];
   logic [QW-1:0] raw_hi [2];
   logic [QW-1:0] cl_lo  [2];
   logic [QW-1:0] cl_hi  [2];
   logic [QW-1:0] raw_gain_q;

   logic [QW-1:0] lim1_o [2];
   logic [QW-1:0] lim2_o [2];

   always_comb begin
      psum_in = SW'(pos_v1) + SW'(pos_v2) + SW'(pos_v3);
      nsum_in = SW'(neg_v1) + SW'(neg_v2) + SW'(neg_v3);
      zero_in = fault_mode ? ((psum_in == '0) || (nsum_in == '0)) : (psum_in == '0);
      accept  = start && !run_q && !zero_in;
   end

   always_comb begin
      div_num = pv1_q;
      div_den = psum_q;
      unique case (job_q)
         hwc_pkg::JOB_P1:   begin div_num = pv1_q;  div_den = psum_q; end
         hwc_pkg::JOB_P2:   begin div_num = pv12_q; div_den = psum_q; end
         hwc_pkg::JOB_N1:   begin div_num = nv1_q;  div_den = nsum_q; end
         hwc_pkg::JOB_N2:   begin div_num = nv12_q; div_den = nsum_q; end
         hwc_pkg::JOB_GAIN: begin
            div_num = (psum_q < nsum_q) ? psum_q : nsum_q;
            div_den = (psum_q < nsum_q) ? nsum_q : psum_q;
         end
         default: ;
      endcase
      last_job = mode_q ? (job_q == hwc_pkg::JOB_GAIN) : (job_q == hwc_pkg::JOB_P2);
   end

   hwc_divider #(.NW(SW), .QW(QW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go_q),
      .num  (div_num),
      .den  (div_den),
      .done (div_done),
      .quot (div_quot)
   );

   for (genvar p = 0; p < 2; p++) begin : g_pol
      hwc_clamp #(.QW(QW), .FW(FW)) u_clamp (
         .raw_lo(raw_lo[p]),
         .raw_hi(raw_hi[p]),
         .lim_lo(cl_lo[p]),
         .lim_hi(cl_hi[p])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         mode_q     <= 1'b0;
         pv1_q      <= '0;
         pv12_q     <= '0;
         psum_q     <= '0;
         nv1_q      <= '0;
         nv12_q     <= '0;
         nsum_q     <= '0;
         job_q      <= hwc_pkg::JOB_P1;
         go_q       <= 1'b0;
         commit_q   <= 1'b0;
         raw_lo[0]  <= '0;
         raw_hi[0]  <= '0;
         raw_lo[1]  <= '0;
         raw_hi[1]  <= '0;
         raw_gain_q <= ONE;
         lim1_o[0]  <= '0;
         lim2_o[0]  <= '0;
         lim1_o[1]  <= '0;
         lim2_o[1]  <= '0;
         gain       <= ONE;
         gain_neg   <= 1'b0;
         valid      <= 1'b0;
      end else begin
         go_q     <= 1'b0;
         commit_q <= 1'b0;
         valid    <= 1'b0;
         if (accept) begin
            run_q  <= 1'b1;
            mode_q <= fault_mode;
            pv1_q  <= SW'(pos_v1);
            pv12_q <= SW'(pos_v1) + SW'(pos_v2);
            psum_q <= psum_in;
            nv1_q  <= SW'(neg_v1);
            nv12_q <= SW'(neg_v1) + SW'(neg_v2);
            nsum_q <= nsum_in;
            job_q  <= hwc_pkg::JOB_P1;
            go_q   <= 1'b1;
         end else if (div_done) begin
            unique case (job_q)
               hwc_pkg::JOB_P1:   raw_lo[0]  <= div_quot;
               hwc_pkg::JOB_P2:   raw_hi[0]  <= div_quot;
               hwc_pkg::JOB_N1:   raw_lo[1]  <= div_quot;
               hwc_pkg::JOB_N2:   raw_hi[1]  <= div_quot;
               hwc_pkg::JOB_GAIN: raw_gain_q <= div_quot;
               default: ;
            endcase
            if (last_job) begin
               commit_q <= 1'b1;
            end else begin
               job_q <= hwc_pkg::job_e'(job_q + 3'd1);
               go_q  <= 1'b1;
            end
         end
         if (commit_q) begin
            run_q     <= 1'b0;
            valid     <= 1'b1;
            lim1_o[0] <= cl_lo[0];
            lim2_o[0] <= cl_hi[0];
            lim1_o[1] <= mode_q ? cl_lo[1] : cl_lo[0];
            lim2_o[1] <= mode_q ? cl_hi[1] : cl_hi[0];
            gain      <= mode_q ? raw_gain_q : ONE;
            gain_neg  <= mode_q && (nsum_q > psum_q);
         end
      end
   end

   assign pos_lim0 = '0;
   assign pos_lim1 = lim1_o[0];
   assign pos_lim2 = lim2_o[0];
   assign pos_lim3 = ONE;
   assign neg_lim0 = '0;
   assign neg_lim1 = lim1_o[1];
   assign neg_lim2 = lim2_o[1];
   assign neg_lim3 = ONE;
endmodule

// File: rtl/hwc_comp_chk.sv
module hwc_comp_chk #(
   parameter int VW = 12,
   parameter int FW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fault_mode,
   input logic          start,
   input logic          busy,
   input logic          mode,
   input logic [VW-1:0] pos_v1,
   input logic [VW-1:0] pos_v2,
   input logic [VW-1:0] pos_v3,
   input logic [VW-1:0] neg_v1,
   input logic [VW-1:0] neg_v2,
   input logic [VW-1:0] neg_v3,
   input logic [FW:0]   pos_lim0,
   input logic [FW:0]   pos_lim1,
   input logic [FW:0]   pos_lim2,
   input logic [FW:0]   pos_lim3,
   input logic [FW:0]   neg_lim0,
   input logic [FW:0]   neg_lim1,
   input logic [FW:0]   neg_lim2,
   input logic [FW:0]   neg_lim3,
   input logic [FW:0]   gain,
   input logic          gain_neg,
   input logic          valid
);
   localparam logic [FW:0] ONE = (FW+1)'(1) << FW;

   logic p_zero, n_zero, zero_need;
   always_comb begin
      p_zero    = (pos_v1 == '0) && (pos_v2 == '0) && (pos_v3 == '0);
      n_zero    = (neg_v1 == '0) && (neg_v2 == '0) && (neg_v3 == '0);
      zero_need = fault_mode ? (p_zero || n_zero) : p_zero;
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R9
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(pos_lim1) && $stable(pos_lim2) && $stable(neg_lim1)
                  && $stable(neg_lim2) && $stable(gain) && $stable(gain_neg))); // R9
   AST_ORDER_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_lim0 <= pos_lim1) && (pos_lim1 <= pos_lim2) && (pos_lim2 <= pos_lim3)); // R10
   AST_ORDER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (neg_lim0 <= neg_lim1) && (neg_lim1 <= neg_lim2) && (neg_lim2 <= neg_lim3)); // R10
   AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gain <= ONE); // R5
   AST_FLAG_BELOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      gain_neg |-> (gain < ONE)); // R5
   AST_NORMAL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !mode) |-> ((neg_lim1 == pos_lim1) && (neg_lim2 == pos_lim2)
                            && (gain == ONE) && !gain_neg)); // R7
   AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && zero_need) |=> !busy); // R8
endmodule

bind hw_limit_comp hwc_comp_chk #(.VW(VW), .FW(FW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fault_mode(fault_mode),
   .start     (start),
   .busy      (run_q),
   .mode      (mode_q),
   .pos_v1    (pos_v1),
   .pos_v2    (pos_v2),
   .pos_v3    (pos_v3),
   .neg_v1    (neg_v1),
   .neg_v2    (neg_v2),
   .neg_v3    (neg_v3),
   .pos_lim0  (pos_lim0),
   .pos_lim1  (pos_lim1),
   .pos_lim2  (pos_lim2),
   .pos_lim3  (pos_lim3),
   .neg_lim0  (neg_lim0),
   .neg_lim1  (neg_lim1),
   .neg_lim2  (neg_lim2),
   .neg_lim3  (neg_lim3),
   .gain      (gain),
   .gain_neg  (gain_neg),
   .valid     (valid)
);

// File: tb/hw_limit_comp_test.sv
module hw_limit_comp_test;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 4;
   localparam int FW = 15;
   localparam int ONE = 32768;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fault_mode = 1'b0;
   logic start = 1'b0;
   logic [VW-1:0] pos_v1 = '0, pos_v2 = '0, pos_v3 = '0;
   logic [VW-1:0] neg_v1 = '0, neg_v2 = '0, neg_v3 = '0;
   logic [FW:0] pos_lim0, pos_lim1, pos_lim2, pos_lim3;
   logic [FW:0] neg_lim0, neg_lim1, neg_lim2, neg_lim3;
   logic [FW:0] gain;
   logic gain_neg, valid;

   int n_run = 0;
   int n_fail = 0;
   int e_p1 = 0, e_p2 = 0, e_n1 = 0, e_n2 = 0, e_g = ONE, e_f = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hw_limit_comp #(.VW(VW), .FW(FW)) uut (
      .clk(clk), .rst_n(rst_n), .fault_mode(fault_mode), .start(start),
      .pos_v1(pos_v1), .pos_v2(pos_v2), .pos_v3(pos_v3),
      .neg_v1(neg_v1), .neg_v2(neg_v2), .neg_v3(neg_v3),
      .pos_lim0(pos_lim0), .pos_lim1(pos_lim1), .pos_lim2(pos_lim2), .pos_lim3(pos_lim3),
      .neg_lim0(neg_lim0), .neg_lim1(neg_lim1), .neg_lim2(neg_lim2), .neg_lim3(neg_lim3),
      .gain(gain), .gain_neg(gain_neg), .valid(valid)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int qdiv(input int n, input int d);
      return (n * ONE) / d;
   endfunction

   task automatic check_outputs();
      chk("R1 pos_lim0", int'(pos_lim0), 0);
      chk("R1 neg_lim3", int'(neg_lim3), ONE);
      chk("R2 pos_lim1", int'(pos_lim1), e_p1);
      chk("R3 pos_lim2", int'(pos_lim2), e_p2);
      chk(fault_mode ? "R4 neg_lim1" : "R7 neg_lim1", int'(neg_lim1), e_n1);
      chk(fault_mode ? "R4 neg_lim2" : "R7 neg_lim2", int'(neg_lim2), e_n2);
      chk((e_g == ONE) ? "R6 gain" : "R5 gain", int'(gain), e_g);
      chk((e_g == ONE) ? "R6 gain_neg" : "R5 gain_neg", int'(gain_neg), e_f);
      chk("R10 order", int'(pos_lim1 <= pos_lim2 && neg_lim1 <= neg_lim2), 1);
   endtask

   task automatic run_case(input logic fm, input int p1, input int p2, input int p3,
                           input int n1, input int n2, input int n3);
      int ps, ns;
      bit upd, seen;
      ps = p1 + p2 + p3;
      ns = n1 + n2 + n3;
      upd = fm ? (ps != 0 && ns != 0) : (ps != 0);
      if (upd) begin
         e_p1 = qdiv(p1, ps);
         e_p2 = qdiv(p1 + p2, ps);
         if (fm) begin
            e_n1 = qdiv(n1, ns);
            e_n2 = qdiv(n1 + n2, ns);
            e_g  = (ps < ns) ? qdiv(ps, ns) : qdiv(ns, ps);
            e_f  = (ns > ps) ? 1 : 0;
         end else begin
            e_n1 = e_p1;
            e_n2 = e_p2;
            e_g  = ONE;
            e_f  = 0;
         end
      end
      @(negedge clk);
      fault_mode = fm;
      pos_v1 = VW'(p1); pos_v2 = VW'(p2); pos_v3 = VW'(p3);
      neg_v1 = VW'(n1); neg_v2 = VW'(n2); neg_v3 = VW'(n3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 0;
      for (int i = 0; i < 150; i++) begin
         if (valid) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      if (upd) begin
         chk("R9 valid seen", int'(seen), 1);
         check_outputs();
         @(negedge clk);
         chk("R9 valid pulse", int'(valid), 0);
      end else begin
         chk("R8 no valid on zero sum", int'(seen), 0);
         check_outputs();
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int vals[5] = '{0, 2, 5, 9, 15};
      int negs[5][3] = '{'{1, 2, 3}, '{9, 5, 2}, '{0, 0, 0}, '{15, 15, 15}, '{9, 9, 9}};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R1 reset pos_lim3", int'(pos_lim3), ONE);
      chk("R9 reset valid", int'(valid), 0);
      chk("R10 reset pos_lim1", int'(pos_lim1), 0);
      chk("R6 reset gain", int'(gain), ONE);

      // Normal mode: negative inputs differ and must not matter
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int c = 0; c < 5; c++)
               run_case(1'b0, vals[a], vals[b], vals[c],
                        (vals[a] + 3) % 16, 7, (vals[c] + 11) % 16);

      // Fault mode: independent sets, equal/lesser/greater sums, zero sets
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int c = 0; c < 5; c++)
               for (int k = 0; k < 5; k++)
                  run_case(1'b1, vals[a], vals[b], vals[c],
                           negs[k][0], negs[k][1], negs[k][2]);

      // Start while busy: second request must be dropped
      e_p1 = qdiv(3, 10); e_p2 = qdiv(7, 10);
      e_n1 = qdiv(8, 14); e_n2 = qdiv(9, 14);
      e_g = qdiv(10, 14); e_f = 1;
      @(negedge clk);
      fault_mode = 1'b1;
      pos_v1 = 4'd3; pos_v2 = 4'd4; pos_v3 = 4'd3;
      neg_v1 = 4'd8; neg_v2 = 4'd1; neg_v3 = 4'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      pos_v1 = 4'd15; pos_v2 = 4'd1; pos_v3 = 4'd1;
      neg_v1 = 4'd1; neg_v2 = 4'd1; neg_v3 = 4'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 150; i++) begin
         if (valid) break;
         @(negedge clk);
      end
      chk("R9 busy start valid", int'(valid), 1);
      check_outputs();
      repeat (150) @(negedge clk);
      chk("R9 no second result", int'(pos_lim1), e_p1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule